// File: doc/BRIEF.md
# Triggerable Capture Timer Pair

The block holds two capture timer channels, an even one and an odd one. Each channel has a counter, a capture register and a control register. A 5-bit select field in the control register picks one of up to 32 external event lines. In trigger mode a channel keeps its counter at zero until the selected line fires, then counts until software clears its run flag. In synchronization mode the counter runs freely and the selected line resets it to zero each time the line pulses.

A rising edge on a channel's capture input copies the current count into its capture register. Every event line and capture input passes through a two-flop synchronizer and a rising-edge detector before the channels see it. If both channels set their cascade bit, the pair acts as one counter twice as wide. The even channel then supplies the low half and all control. The odd channel supplies the high half and takes its captures from the even channel's capture input.

Top module: `tcap_pair`

## Requirements
- R1: After reset each control register reads 0x000D (select = 5'b01101, all other fields 0), and every counter and capture register holds 0.
- R2: Control register read layout: [8] cascade, [7] mode (1 = trigger, 0 = sync), [6] run status, [4:0] select. Bits [15:9] and [5] always read 0, and writing ones to them has no effect.
- R3: In trigger mode, while the run status is 0, the counter is held at 0.
- R4: In trigger mode, a detected rising edge on the selected line sets the run status on that clock. The counter reads 1 one clock later and then increments every clock.
- R5: A software write sets or clears the run status. Setting it starts the count from 0. Clearing it returns the count to 0 on the next clock. A write wins over a hardware event in the same clock.
- R6: In sync mode the counter increments every clock and wraps modulo 2^CW. A detected rising edge on the selected line forces it to 0 on that clock.
- R7: A level change on an event line or capture input takes effect on the third rising clock edge after it. A level that stays high produces only one event.
- R8: A channel's own select code (OWN_SEL_E for the even channel, OWN_SEL_O for the odd one) never produces an event, in either mode.
- R9: The code TONLY_SEL produces no event in sync mode but does work as a trigger in trigger mode.
- R10: The channels are cascaded only when both cascade bits are 1. The odd counter then increments when the even counter wraps and clears with it. Otherwise the two counters run independently.
- R11: A capture event loads the count from just before that edge into the capture register. When cascaded, the even capture input loads both halves on the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | NSRC | Asynchronous event lines for trigger or sync |
| cap_in | input | 2 | Asynchronous capture inputs, [0] even, [1] odd |
| ctl_we | input | 2 | Control write strobes, [0] even, [1] odd |
| ctl_wdata | input | 16 | Control write data |
| ctl_rdata | output | 32 | Control read-back, [15:0] even, [31:16] odd |
| tmr_q | output | 2*CW | Counters, [CW-1:0] even, upper half odd |
| cap_q | output | 2*CW | Capture registers, same split as tmr_q |

## Verification
The bench builds the block with CW = 8, NSRC = 32, OWN_SEL_E = 1, OWN_SEL_O = 2 and TONLY_SEL = 31. The 8-bit counter wraps after 256 clocks, so a short run reaches the sync-mode wrap and the carry from the even half into the odd half. The cascaded value of 300 can then be checked exactly as 0x01 over 0x2C. With 32 lines every 5-bit code is a real line, so the self code and the trigger-only code can be pulsed directly and shown to have no effect.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
   localparam int unsigned CTL_W   = 16;
   localparam int unsigned SEL_W   = 5;
   localparam int unsigned B_CASC  = 8;
   localparam int unsigned B_MODE  = 7;
   localparam int unsigned B_STAT  = 6;
   localparam logic [SEL_W-1:0] SEL_RST = 5'b01101;

   typedef struct packed {
      logic             casc;
      logic             mode;
      logic             stat;
      logic [SEL_W-1:0] sel;
   } ctl_t;

   function automatic logic [CTL_W-1:0] ctl_pack(input ctl_t c);
      return {7'b0, c.casc, c.mode, c.stat, 1'b0, c.sel};
   endfunction
endpackage

// File: rtl/tcap_sync.sv
module tcap_sync #(
   parameter int unsigned W      = 34,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] rise
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("tcap_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stg [STAGES+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i <= STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= din;
         for (int i = 1; i <= STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign rise = stg[STAGES-1] & ~stg[STAGES];
endmodule

// File: rtl/tcap_chan.sv
module tcap_chan
   import tcap_pkg::*;
#(
   parameter int unsigned CW        = 16,
   parameter int unsigned NSRC      = 32,
   parameter int unsigned OWN_SEL   = 1,
   parameter int unsigned TONLY_SEL = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CTL_W-1:0] wdata,
   input  logic [NSRC-1:0]  src_rise,
   input  logic             cap_fire,
   input  logic             slave,
   input  logic             inc_i,
   input  logic             clr_i,
   output logic [CTL_W-1:0] ctl_rd,
   output logic             inc_o,
   output logic             clr_o,
   output logic             carry_o,
   output logic [CW-1:0]    cnt_o,
   output logic [CW-1:0]    cap_o
);
   localparam logic [CW-1:0]    ONE    = CW'(1);
   localparam logic [SEL_W-1:0] OWN_C  = SEL_W'(OWN_SEL);
   localparam logic [SEL_W-1:0] TONL_C = SEL_W'(TONLY_SEL);

   generate
      if (CW < 2) begin : g_bad_cw
         $error("tcap_chan: CW must be at least 2");
      end
      if (OWN_SEL >= 32 || TONLY_SEL >= 32) begin : g_bad_sel
         $error("tcap_chan: select codes must fit in 5 bits");
      end
   endgenerate

   ctl_t          ctl;
   logic [31:0]   rise_pad;
   logic          ev, own_clr, clr, inc;
   logic [CW-1:0] cnt, cap;
   logic          unused_wbits;

   assign unused_wbits = ^{wdata[15:9], wdata[5]};
   assign rise_pad     = 32'(src_rise);

   always_comb begin
      ev = rise_pad[ctl.sel];
      if (ctl.sel == OWN_C) ev = 1'b0;
      if (!ctl.mode && ctl.sel == TONL_C) ev = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= '{casc: 1'b0, mode: 1'b0, stat: 1'b0, sel: SEL_RST};
      end else if (we) begin
         ctl <= '{casc: wdata[B_CASC], mode: wdata[B_MODE],
                  stat: wdata[B_STAT], sel: wdata[SEL_W-1:0]};
      end else if (ctl.mode && ev) begin
         ctl.stat <= 1'b1;
      end
   end

   assign own_clr = ctl.mode ? !ctl.stat : ev;
   assign clr     = slave ? clr_i : own_clr;
   assign inc     = slave ? inc_i : !own_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= cnt + ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cap <= '0;
      else if (cap_fire) cap <= cnt;
   end

   assign ctl_rd  = ctl_pack(ctl);
   assign inc_o   = !own_clr;
   assign clr_o   = own_clr;
   assign carry_o = &cnt;
   assign cnt_o   = cnt;
   assign cap_o   = cap;

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!slave && ctl.mode && !ctl.stat) |=> (cnt == '0));

   p_hwset_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!we && ctl.mode && rise_pad[ctl.sel] && ctl.sel != OWN_C) |=> ctl.stat);

   p_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!slave && ctl.mode && ctl.stat) |=> (cnt == $past(cnt) + ONE));

   p_syncclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!slave && !ctl.mode && rise_pad[ctl.sel] && ctl.sel != OWN_C
       && ctl.sel != TONL_C) |=> (cnt == '0));

   p_own_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!slave && !ctl.mode && ctl.sel == OWN_C) |=> (cnt == $past(cnt) + ONE));

   p_tonly_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!slave && !ctl.mode && ctl.sel == TONL_C) |=> (cnt == $past(cnt) + ONE));

   p_cap_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cap_fire |=> (cap == $past(cnt)));
endmodule

// File: rtl/tcap_pair.sv
module tcap_pair
   import tcap_pkg::*;
#(
   parameter int unsigned CW        = 16,
   parameter int unsigned NSRC      = 32,
   parameter int unsigned OWN_SEL_E = 1,
   parameter int unsigned OWN_SEL_O = 2,
   parameter int unsigned TONLY_SEL = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_in,
   input  logic [1:0]        cap_in,
   input  logic [1:0]        ctl_we,
   input  logic [CTL_W-1:0]  ctl_wdata,
   output logic [2*CTL_W-1:0] ctl_rdata,
   output logic [2*CW-1:0]   tmr_q,
   output logic [2*CW-1:0]   cap_q
);
   localparam int unsigned SW  = NSRC + 2;
   localparam logic [CW-1:0] ONE = CW'(1);

   generate
      if (NSRC < 1 || NSRC > 32) begin : g_bad_nsrc
         $error("tcap_pair: NSRC must be 1..32");
      end
   endgenerate

   logic [SW-1:0]    rise_all;
   logic [NSRC-1:0]  src_rise;
   logic [1:0]       cap_rise;
   logic [CTL_W-1:0] ctl [2];
   logic [CW-1:0]    cnt [2];
   logic [CW-1:0]    cap [2];
   logic [1:0]       inc, clr, carry;
   logic             casc_on;
   logic             unused_odd;

   tcap_sync #(.W(SW), .STAGES(2)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({cap_in, src_in}),
      .rise (rise_all)
   );

   assign src_rise   = rise_all[NSRC-1:0];
   assign cap_rise   = rise_all[SW-1:NSRC];
   assign casc_on    = ctl[0][B_CASC] & ctl[1][B_CASC];
   assign unused_odd = carry[1] ^ inc[1] ^ clr[1];

   for (genvar g = 0; g < 2; g++) begin : g_ch
      localparam int unsigned OWN = (g == 0) ? OWN_SEL_E : OWN_SEL_O;
      logic slave, inc_in, clr_in, fire;
      if (g == 0) begin : g_even
         assign slave  = 1'b0;
         assign inc_in = 1'b0;
         assign clr_in = 1'b0;
         assign fire   = cap_rise[0];
      end else begin : g_odd
         assign slave  = casc_on;
         assign inc_in = inc[0] & carry[0];
         assign clr_in = clr[0];
         assign fire   = casc_on ? cap_rise[0] : cap_rise[1];
      end

      tcap_chan #(
         .CW(CW), .NSRC(NSRC), .OWN_SEL(OWN), .TONLY_SEL(TONLY_SEL)
      ) u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .we      (ctl_we[g]),
         .wdata   (ctl_wdata),
         .src_rise(src_rise),
         .cap_fire(fire),
         .slave   (slave),
         .inc_i   (inc_in),
         .clr_i   (clr_in),
         .ctl_rd  (ctl[g]),
         .inc_o   (inc[g]),
         .clr_o   (clr[g]),
         .carry_o (carry[g]),
         .cnt_o   (cnt[g]),
         .cap_o   (cap[g])
      );

      assign ctl_rdata[g*CTL_W +: CTL_W] = ctl[g];
      assign tmr_q[g*CW +: CW]           = cnt[g];
      assign cap_q[g*CW +: CW]           = cap[g];
   end

   p_carry_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (casc_on && inc[0] && carry[0]) |=> (cnt[1] == $past(cnt[1]) + ONE));

   p_hold_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (casc_on && inc[0] && !carry[0]) |=> $stable(cnt[1]));

   p_clr_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (casc_on && clr[0]) |=> (cnt[1] == '0));
endmodule

// File: tb/tb_tcap_pair.sv
module tb_tcap_pair;
   localparam int CW = 8;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] src_in;
   logic [1:0]  cap_in;
   logic [1:0]  ctl_we;
   logic [15:0] ctl_wdata;
   logic [31:0] ctl_rdata;
   logic [15:0] tmr_q;
   logic [15:0] cap_q;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #10 clk = ~clk;

   tcap_pair #(.CW(CW), .NSRC(32), .OWN_SEL_E(1), .OWN_SEL_O(2), .TONLY_SEL(31)) dut (
      .clk(clk), .rst_n(rst_n), .src_in(src_in), .cap_in(cap_in),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .tmr_q(tmr_q), .cap_q(cap_q)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int ch, input logic [15:0] d);
      @(negedge clk);
      ctl_we[ch] = 1'b1;
      ctl_wdata  = d;
      @(negedge clk);
      ctl_we = 2'b00;
   endtask

   task automatic pulse(input int idx);
      src_in[idx] = 1'b1;
      tick(1);
      src_in[idx] = 1'b0;
      tick(2);
   endtask

   function automatic logic [7:0] ev_cnt();
      return tmr_q[7:0];
   endfunction

   function automatic logic [7:0] od_cnt();
      return tmr_q[15:8];
   endfunction

   function automatic logic ev_stat();
      return ctl_rdata[6];
   endfunction

   task automatic t_reset();
      rst_n = 1'b0; src_in = '0; cap_in = '0; ctl_we = '0; ctl_wdata = '0;
      tick(3);
      check("R1 ctl", ctl_rdata, 32'h000D_000D);
      check("R1 tmr", tmr_q, 16'h0);
      check("R1 cap", cap_q, 16'h0);
      rst_n = 1'b1;
   endtask

   task automatic t_layout();
      wr(0, 16'hFFFF);
      check("R2 unused bits", ctl_rdata[15:0], 16'h01DF);
      wr(0, 16'h0000);
      check("R2 cleared", ctl_rdata[15:0], 16'h0000);
   endtask

   task automatic t_sync();
      logic [7:0] c0;
      wr(0, 16'h0005);
      pulse(5);
      check("R6 clear", ev_cnt(), 8'd0);
      tick(1);
      check("R6 inc", ev_cnt(), 8'd1);
      tick(9);
      check("R6 inc10", ev_cnt(), 8'd10);
      c0 = ev_cnt();
      src_in[5] = 1'b1;
      tick(2);
      check("R7 not yet", ev_cnt(), 32'(8'(c0 + 8'd2)));
      tick(1);
      check("R7 third edge", ev_cnt(), 8'd0);
      tick(5);
      check("R7 held level", ev_cnt(), 8'd5);
      src_in[5] = 1'b0;
      tick(250);
      check("R6 top", ev_cnt(), 8'd255);
      tick(1);
      check("R6 wrap", ev_cnt(), 8'd0);
   endtask

   task automatic t_capture();
      logic [7:0] e0, e1;
      cap_in[0] = 1'b1; tick(1); cap_in[0] = 1'b0; tick(1);
      e0 = ev_cnt(); tick(1);
      check("R11 even cap", cap_q[7:0], e0);
      cap_in[1] = 1'b1; tick(1); cap_in[1] = 1'b0; tick(1);
      e1 = od_cnt(); tick(1);
      check("R11 odd cap", cap_q[15:8], e1);
      check("R11 even kept", cap_q[7:0], e0);
   endtask

   task automatic t_trigger();
      wr(0, 16'h0085);
      check("R4 stat idle", ev_stat(), 1'b0);
      tick(1);
      check("R3 held", ev_cnt(), 8'd0);
      tick(4);
      check("R3 still held", ev_cnt(), 8'd0);
      pulse(5);
      check("R4 stat set", ev_stat(), 1'b1);
      check("R4 cnt zero", ev_cnt(), 8'd0);
      tick(1);
      check("R4 first", ev_cnt(), 8'd1);
      tick(6);
      check("R4 run", ev_cnt(), 8'd7);
   endtask

   task automatic t_softstat();
      wr(0, 16'h0085);
      check("R5 sw clear", ev_stat(), 1'b0);
      tick(1);
      check("R5 back to 0", ev_cnt(), 8'd0);
      tick(3);
      check("R5 held", ev_cnt(), 8'd0);
      wr(0, 16'h00C5);
      check("R5 sw set", ev_stat(), 1'b1);
      tick(1);
      check("R5 start", ev_cnt(), 8'd1);
      tick(2);
      check("R5 run", ev_cnt(), 8'd3);
      src_in[5] = 1'b1; tick(1); src_in[5] = 1'b0; tick(1);
      ctl_we[0] = 1'b1; ctl_wdata = 16'h0085; tick(1); ctl_we = 2'b00;
      check("R5 write wins", ev_stat(), 1'b0);
      tick(1);
      check("R5 write wins cnt", ev_cnt(), 8'd0);
   endtask

   task automatic t_own();
      logic [7:0] c0;
      wr(0, 16'h0001);
      c0 = ev_cnt();
      pulse(1);
      check("R8 sync ignored", ev_cnt(), 32'(8'(c0 + 8'd3)));
      wr(0, 16'h0081);
      tick(1);
      pulse(1);
      check("R8 trig ignored", ev_stat(), 1'b0);
      check("R8 trig cnt", ev_cnt(), 8'd0);
   endtask

   task automatic t_tonly();
      logic [7:0] c0;
      wr(0, 16'h001F);
      c0 = ev_cnt();
      pulse(31);
      check("R9 sync ignored", ev_cnt(), 32'(8'(c0 + 8'd3)));
      wr(0, 16'h009F);
      pulse(31);
      check("R9 trigger works", ev_stat(), 1'b1);
   endtask

   task automatic t_cascade();
      logic [15:0] e;
      wr(1, 16'h0080);
      wr(0, 16'h0105);
      pulse(5);
      check("R10 split even", ev_cnt(), 8'd0);
      check("R10 split odd", od_cnt(), 8'd0);
      tick(255);
      check("R10 split top", ev_cnt(), 8'd255);
      tick(1);
      check("R10 no carry", od_cnt(), 8'd0);
      wr(1, 16'h0180);
      pulse(5);
      check("R10 joint clear", tmr_q, 16'h0000);
      tick(300);
      check("R10 carry", tmr_q, 16'h012C);
      cap_in[0] = 1'b1; tick(1); cap_in[0] = 1'b0; tick(1);
      e = tmr_q; tick(1);
      check("R11 joint cap", cap_q, e);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_layout();
      t_sync();
      t_capture();
      t_trigger();
      t_softstat();
      t_own();
      t_tonly();
      t_cascade();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule